// File: doc/BRIEF.md
# Guarded Power-Mode Entry Controller

This block decides whether a microcontroller core is allowed to drop into idle or power-down. One protection pin serves two purposes. Its level at the moment reset is released is captured once and drives a watchdog auto-start output. Its live level separately gates a two-write entry sequence to the power-control register. The pin defaults high, so an undriven board gets full protection: power saving is blocked and the watchdog starts by itself.

The pin first passes through a synchronizer. It is then sampled only on a machine-phase strobe, which the core raises once per machine cycle. Between strobes the last sampled level is held. To enter a mode, software first writes the mode's enable bit. The very next register write must then set the matching mode bit. A granted request stays asserted until a wake input or reset clears it. The clock gating and the watchdog counter are outside this block.

Top module: `pmode_guard`

## Requirements
- R1: While `rst` is high, `wdt_start` follows the synchronized pin. After release it holds the synchronized pin level from the last clock edge at which `rst` was high.
- R2: After reset release, no change on `prot_pin` alters `wdt_start` until the next reset.
- R3: The gating level is updated from the synchronized pin only on edges where `phase_stb` is high, and is held otherwise. It is forced high while `rst` is high, so entry stays blocked until the first strobe after reset.
- R4: When the gating level is high, a completing sequence asserts neither request and clears the armed state.
- R5: With the gating level low, a write with bit 2 (idle enable) set, followed by the next write with bit 0 (idle mode) set, raises `idle_req` one cycle after the second write.
- R6: With the gating level low, a write with bit 3 (power-down enable) set, followed by the next write with bit 1 (power-down mode) set, raises `pd_req` one cycle after the second write.
- R7: Every write that does not complete a sequence replaces the armed enables with its own bits 3 and 2. An intervening write without those bits therefore disarms the sequence.
- R8: If both modes are armed and one completing write sets bits 0 and 1, only `pd_req` is asserted. The two requests are never high together.
- R9: An asserted request stays high until `wake` is high at a clock edge, and it drops on that edge. While a request is high, register writes are ignored and leave nothing armed.
- R10: While `rst` is high, both requests are driven low and the armed state is cleared.
- R11: A mode-bit write with no preceding enable write asserts no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_pin | input | 1 | Asynchronous protection pin, high blocks power saving |
| phase_stb | input | 1 | One-cycle strobe at the machine phase where the pin is sampled |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | DATA_W | Write data: bit0 idle mode, bit1 power-down mode, bit2 idle enable, bit3 power-down enable |
| wake | input | 1 | Clears an active mode request |
| idle_req | output | 1 | Registered idle-mode request |
| pd_req | output | 1 | Registered power-down request |
| wdt_start | output | 1 | Watchdog auto-start level captured at reset release |

## Verification
The checks assume that `phase_stb` is a single-cycle pulse. They also assume that `wake`, `wr_en` and `wr_data` change only between clock edges. The stimulus keeps `prot_pin` steady for several cycles around each reset release, so that the synchronized level the capture sees is well defined. The bench drives every input on the falling edge. It pulses the strobe on every fourth cycle, and it holds reset for several cycles so the synchronizer fills before release.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  // Field positions inside a power-control register write
  localparam int unsigned IDLE_MODE_BIT = 0;
  localparam int unsigned PD_MODE_BIT   = 1;
  localparam int unsigned IDLE_ARM_BIT  = 2;
  localparam int unsigned PD_ARM_BIT    = 3;
  localparam int unsigned MIN_DATA_W    = 4;

  typedef struct packed {
    logic pd;
    logic idle;
  } mode_pair_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain[0] <= d;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_guard_sample.sv
module pm_guard_sample (
  input  logic clk,
  input  logic rst,
  input  logic pin_sync,
  input  logic phase_stb,
  output logic prot_q,
  output logic wdt_start
);
  // Live gating level: refreshed only at the sampling phase
  always_ff @(posedge clk) begin
    if (rst)            prot_q <= 1'b1;
    else if (phase_stb) prot_q <= pin_sync;
  end

  // Auto-start level: tracks the pin during reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) wdt_start <= pin_sync;
  end
endmodule

// File: rtl/pm_entry_seq.sv
module pm_entry_seq
  import pmode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_q,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake,
  output mode_pair_t        req
);
  mode_pair_t armed;
  mode_pair_t hit;
  logic       busy;

  assign busy     = req.idle | req.pd;
  assign hit.pd   = armed.pd & wr_data[PD_MODE_BIT];
  assign hit.idle = armed.idle & wr_data[IDLE_MODE_BIT] & ~hit.pd;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= '0;
      req   <= '0;
    end else if (busy) begin
      armed <= '0;
      if (wake) req <= '0;
    end else if (wr_en) begin
      if (hit.pd | hit.idle) begin
        armed <= '0;
        if (!prot_q) req <= hit;
      end else begin
        armed.pd   <= wr_data[PD_ARM_BIT];
        armed.idle <= wr_data[IDLE_ARM_BIT];
      end
    end
  end
endmodule

// File: rtl/pmode_guard.sv
module pmode_guard
  import pmode_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_pin,
  input  logic              phase_stb,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake,
  output logic              idle_req,
  output logic              pd_req,
  output logic              wdt_start
);
  localparam int unsigned CHK_W = (DATA_W >= MIN_DATA_W) ? 1 : 0;

  logic       pin_sync;
  logic       prot_q;
  mode_pair_t req;

  initial begin
    if (CHK_W == 0) $error("DATA_W too narrow for the control fields");
  end

  pm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (prot_pin),
    .q   (pin_sync)
  );

  pm_guard_sample u_sample (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .phase_stb (phase_stb),
    .prot_q    (prot_q),
    .wdt_start (wdt_start)
  );

  pm_entry_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .prot_q  (prot_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wake    (wake),
    .req     (req)
  );

  assign idle_req = req.idle;
  assign pd_req   = req.pd;
endmodule

// File: rtl/pmode_guard_chk.sv
module pmode_guard_chk (
  input logic clk,
  input logic rst,
  input logic wake,
  input logic phase_stb,
  input logic prot_q,
  input logic idle_req,
  input logic pd_req,
  input logic wdt_start
);
  // R10
  req_reset_low_chk: assert property (@(posedge clk) rst |=> (!idle_req && !pd_req));

  // R2
  wdt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(wdt_start));

  // R8
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(idle_req && pd_req));

  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_req && !wake) |=> pd_req);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_req && !wake) |=> idle_req);

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !phase_stb |=> $stable(prot_q));

  // R4
  blocked_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && !idle_req && !pd_req) |=> (!idle_req && !pd_req));
endmodule

bind pmode_guard pmode_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wake      (wake),
  .phase_stb (phase_stb),
  .prot_q    (prot_q),
  .idle_req  (idle_req),
  .pd_req    (pd_req),
  .wdt_start (wdt_start)
);

// File: tb/pmode_guard_bench.sv
`timescale 1ns/1ps
module pmode_guard_bench;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_pin = 1'b1;
  logic phase_stb = 1'b0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wake = 1'b0;
  logic idle_req, pd_req, wdt_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pmode_guard #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_pmode_guard (
    .clk(clk), .rst(rst), .prot_pin(prot_pin), .phase_stb(phase_stb),
    .wr_en(wr_en), .wr_data(wr_data), .wake(wake),
    .idle_req(idle_req), .pd_req(pd_req), .wdt_start(wdt_start)
  );

  // Behavioural reference
  bit m_s1 = 1, m_s2 = 1, m_prot = 1, m_wdt = 1;
  bit m_ai = 0, m_ap = 0, m_idle = 0, m_pd = 0;

  always @(posedge clk) begin
    bit fi, fp, s2_old;
    s2_old = m_s2;
    if (rst) begin
      m_wdt = s2_old; m_prot = 1; m_idle = 0; m_pd = 0; m_ai = 0; m_ap = 0;
    end else begin
      if (m_idle || m_pd) begin
        m_ai = 0; m_ap = 0;
        if (wake) begin m_idle = 0; m_pd = 0; end
      end else if (wr_en) begin
        fp = m_ap && wr_data[1];
        fi = m_ai && wr_data[0] && !fp;
        if (fp || fi) begin
          if (!m_prot) begin m_pd = fp; m_idle = fi; end
          m_ai = 0; m_ap = 0;
        end else begin
          m_ai = wr_data[2]; m_ap = wr_data[3];
        end
      end
      if (phase_stb) m_prot = s2_old;
    end
    m_s2 = m_s1;
    m_s1 = prot_pin;
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // One clock: strobe every fourth cycle, compare on the falling edge
  task automatic tick();
    phase_stb = (cyc % 4 == 3);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check("R5", "idle_req model", idle_req, m_idle);
    check("R6", "pd_req model", pd_req, m_pd);
    if (cyc >= 3) check("R1", "wdt_start model", wdt_start, m_wdt);
    wr_en = 0; wake = 0;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [DATA_W-1:0] d);
    wr_en = 1; wr_data = d; tick();
  endtask

  task automatic do_reset(logic pin);
    prot_pin = pin; rst = 1; idle_n(6); rst = 0;
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        // R10, R1: reset state with the pin high
        do_reset(1'b1);
        check("R10", "idle after reset", idle_req, 1'b0);
        check("R10", "pd after reset", pd_req, 1'b0);
        check("R1", "wdt after high reset", wdt_start, 1'b1);
        idle_n(4);
        // R4: pin high, complete idle sequence -> nothing
        wr(8'h04); wr(8'h01); idle_n(2);
        check("R4", "idle blocked", idle_req, 1'b0);
        // R2: pin low, watchdog keeps its value
        prot_pin = 0; idle_n(8);
        check("R2", "wdt after pin low", wdt_start, 1'b1);
        // R5 + R9
        wr(8'h04); wr(8'h01);
        check("R5", "idle granted", idle_req, 1'b1);
        wr(8'h08); wr(8'h02); idle_n(2);
        check("R9", "idle held, writes ignored", idle_req, 1'b1);
        check("R9", "no pd while busy", pd_req, 1'b0);
        wake = 1; tick();
        check("R9", "idle cleared by wake", idle_req, 1'b0);
        wr(8'h01); idle_n(1);
        check("R9", "nothing armed after busy", idle_req, 1'b0);
        // R6
        wr(8'h08); wr(8'h02);
        check("R6", "pd granted", pd_req, 1'b1);
        wake = 1; tick();
        check("R9", "pd cleared", pd_req, 1'b0);
        // R8
        wr(8'h0C); wr(8'h03);
        check("R8", "pd wins", pd_req, 1'b1);
        check("R8", "idle suppressed", idle_req, 1'b0);
        wake = 1; tick();
        // R7
        wr(8'h04); wr(8'h00); wr(8'h01); idle_n(1);
        check("R7", "broken sequence", idle_req, 1'b0);
        wr(8'h04); wr(8'h08); wr(8'h01); idle_n(1);
        check("R7", "rearm replaced enable", idle_req, 1'b0);
        // R11
        wr(8'h01); wr(8'h02); idle_n(1);
        check("R11", "no arm no request", idle_req | pd_req, 1'b0);
        // R3: pin rises, sequences near the strobe
        prot_pin = 1;
        for (int k = 0; k < 6; k++) begin
          wr(8'h04); wr(8'h01); wake = 1; tick();
        end
        idle_n(4);
        wr(8'h08); wr(8'h02); idle_n(1);
        check("R3", "gate high after strobe", pd_req, 1'b0);
        // Reset mid-request with pin low
        prot_pin = 0; idle_n(8);
        wr(8'h08); wr(8'h02);
        check("R6", "pd before reset", pd_req, 1'b1);
        do_reset(1'b0);
        check("R10", "pd cleared by reset", pd_req, 1'b0);
        check("R1", "wdt after low reset", wdt_start, 1'b0);
        // R3: gate stays high until the first strobe after reset
        wr(8'h04); wr(8'h01);
        check("R3", "blocked before first strobe", idle_req, 1'b0);
        prot_pin = 1; idle_n(10);
        check("R2", "wdt stays low", wdt_start, 1'b0);
        prot_pin = 0; idle_n(8);
        wr(8'h04); wr(8'h01);
        check("R5", "idle after low reset", idle_req, 1'b1);
        idle_n(3);
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule